// File: doc/BRIEF.md
# Three-Byte SPI Register Target for a 128-Step Wiper

This block is an SPI target that sits in front of a 128-position digital potentiometer and owns its register set. A host sends frames of exactly 24 bits while chip select is low. The first byte is a fixed device identifier. The second byte holds an operation code and a register address. The third byte carries the data. The block returns read data on the serial output during the third byte. It drives the 7-bit wiper position that the resistor array, which lies outside this block, would use.

There are three registers. A control register sits at address 3, and its top bit is the bank select. The live wiper register and the power-up value register share address 0, and the bank select decides which of the two a frame reaches. Writing the power-up value also moves the live wiper to that value. Reading the power-up value leaves the live wiper alone. The power-up register is modelled as a plain register with a reset value.

The serial pins are oversampled by the system clock through synchronizers. All state therefore lives in one clock domain.

Top module: `wiper_spi_target`

## Requirements
- R1: After reset the wiper output equals the power-up default of 0x40. The control register reads 0x00, so address 0 reaches the power-up register. A reset applied later restores both values.
- R2: A frame is 24 bits, sent MSB first on sdi and sampled on rising sck while csN is low. Byte 1 must be 0x50. Byte 2 is {op[3:0], two ignored bits, addr[1:0]}. Byte 3 is {ignored bit, value[6:0]}.
- R3: Op 4'b1011 at address 3 writes the full data byte into the control register. Op 4'b1001 at address 3 returns that byte.
- R4: With control bit 7 at 1, a write to address 0 sets the wiper output and leaves the power-up register unchanged.
- R5: With control bit 7 at 0, a write to address 0 sets the power-up register and also sets the wiper output to the same value.
- R6: A read of address 0 returns the register chosen by control bit 7, zero-extended to 8 bits. A read never changes the wiper output, even when the live and power-up values differ.
- R7: In a read frame the data byte leaves on sdo MSB first during the third byte, with sdo updated on falling sck. sdo stays 0 during bytes 1 and 2.
- R8: sdoOe is high while csN is low and drops within three clocks after csN rises. When sdoOe is low the pin is to be treated as high impedance.
- R9: A frame is ignored when its identifier is wrong, its op is neither write nor read, or its address is 1 or 2. Reads of such frames return 0.
- R10: A write frame that ends with csN rising before the 24th rising sck edge changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for sdo |
| wiper | output | 7 | Current wiper position |

## Verification
A wrong bank select or a missed copy into the live wiper shows up on the wiper port a few clocks after the 24th rising sck edge of the offending frame. A corrupted power-up register stays hidden until it is read back through address 0 with bank select cleared, or until the next reset. A bad read mux or a bad output shift register shows up only on sdo during the third byte of the next read. The bench therefore follows every write with reads that expose both registers behind the shared address.

// File: rtl/wiper_spi_pkg.sv
package wiper_spi_pkg;
  // Write strobes sent from the serial control to the register datapath
  typedef struct packed {
    logic       ctlWr;     // write the control register
    logic       sharedWr;  // write the register behind the shared address
    logic [7:0] wdata;
  } strobe_t;
endpackage

// File: rtl/wiper_spi_ctrl.sv
module wiper_spi_ctrl
  import wiper_spi_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  DEV_ID      = 8'h50,
  parameter logic [3:0]  OP_WRITE    = 4'b1011,
  parameter logic [3:0]  OP_READ     = 4'b1001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       sdi,
  input  logic [7:0] rdData,
  output logic [1:0] rdAddr,
  output strobe_t    strb,
  output logic       sdo,
  output logic       sdoOe,
  output logic       csAct,
  output logic       sckFall
);
  localparam int FRAME_BITS = 24;
  localparam int HDR_BITS   = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int TOP        = SYNC_STAGES - 1;
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(HDR_BITS);

  logic [SYNC_STAGES-1:0] csSync, sckSync, sdiSync;
  logic                   sckLast;
  logic                   sckRise;
  logic                   sdiNow;
  logic [CNT_W-1:0]       bitCnt;
  logic [15:0]            shiftReg;
  logic [15:0]            nextWord;
  logic                   isWr, isRd, tgtCtl;
  logic [7:0]             outShift;
  logic                   sdoBit;
  logic                   idOk, mapped, hdrDone, dataDone;
  logic [3:0]             opCode;

  // input synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= '1;
      sckSync <= '0;
      sdiSync <= '0;
    end else begin
      csSync  <= {csSync[TOP-1:0], csN};
      sckSync <= {sckSync[TOP-1:0], sck};
      sdiSync <= {sdiSync[TOP-1:0], sdi};
    end
  end

  assign csAct    = ~csSync[TOP];
  assign sdiNow   = sdiSync[TOP];
  assign sckRise  = csAct &  sckSync[TOP] & ~sckLast;
  assign sckFall  = csAct & ~sckSync[TOP] &  sckLast;
  assign nextWord = {shiftReg[14:0], sdiNow};

  // header decode, valid in the cycle of the 16th rising edge
  assign opCode   = nextWord[7:4];
  assign idOk     = nextWord[15:8] == DEV_ID;
  assign mapped   = (nextWord[1:0] == 2'b00) || (nextWord[1:0] == 2'b11);
  assign hdrDone  = sckRise && (bitCnt == HDR_LAST);
  assign dataDone = sckRise && (bitCnt == DATA_LAST);
  assign rdAddr   = nextWord[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckLast  <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
      isWr     <= 1'b0;
      isRd     <= 1'b0;
      tgtCtl   <= 1'b0;
      outShift <= '0;
      sdoBit   <= 1'b0;
      strb     <= '0;
    end else begin
      sckLast <= sckSync[TOP];
      strb    <= '0;
      if (!csAct) begin
        bitCnt   <= '0;
        isWr     <= 1'b0;
        isRd     <= 1'b0;
        tgtCtl   <= 1'b0;
        outShift <= '0;
        sdoBit   <= 1'b0;
      end else begin
        if (sckRise) begin
          shiftReg <= nextWord;
          if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
          if (hdrDone) begin
            isWr   <= idOk && mapped && (opCode == OP_WRITE);
            isRd   <= idOk && mapped && (opCode == OP_READ);
            tgtCtl <= nextWord[1:0] == 2'b11;
            if (idOk && mapped && (opCode == OP_READ)) outShift <= rdData;
          end
          if (dataDone && isWr) begin
            strb.ctlWr    <= tgtCtl;
            strb.sharedWr <= ~tgtCtl;
            strb.wdata    <= nextWord[7:0];
          end
        end
        if (sckFall && isRd && (bitCnt >= DATA_FIRST)) begin
          sdoBit   <= outShift[7];
          outShift <= {outShift[6:0], 1'b0};
        end
      end
    end
  end

  assign sdo   = sdoBit;
  assign sdoOe = csAct;
endmodule

// File: rtl/wiper_reg_file.sv
module wiper_reg_file
  import wiper_spi_pkg::*;
#(
  parameter int                  WIPER_W  = 7,
  parameter logic [WIPER_W-1:0]  INIT_POS = WIPER_W'(64)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [1:0]         rdAddr,
  output logic [7:0]         rdData,
  output logic [WIPER_W-1:0] wiper
);
  localparam int SEL_BIT = 7;

  logic [7:0]         ctlReg;
  logic [WIPER_W-1:0] liveReg;
  logic [WIPER_W-1:0] bootReg;
  logic               liveSel;

  assign liveSel = ctlReg[SEL_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      bootReg <= INIT_POS;
      liveReg <= INIT_POS;
    end else begin
      if (strb.ctlWr) ctlReg <= strb.wdata;
      if (strb.sharedWr) begin
        liveReg <= strb.wdata[WIPER_W-1:0];
        if (!liveSel) bootReg <= strb.wdata[WIPER_W-1:0];
      end
    end
  end

  always_comb begin
    case (rdAddr)
      2'b11:   rdData = ctlReg;
      2'b00:   rdData = liveSel ? 8'(liveReg) : 8'(bootReg);
      default: rdData = 8'h00;
    endcase
  end

  assign wiper = liveReg;
endmodule

// File: rtl/wiper_spi_target.sv
module wiper_spi_target
  import wiper_spi_pkg::*;
#(
  parameter int                  WIPER_W     = 7,
  parameter logic [WIPER_W-1:0]  INIT_POS    = WIPER_W'(64),
  parameter int                  SYNC_STAGES = 2,
  parameter logic [7:0]          DEV_ID      = 8'h50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sck,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdoOe,
  output logic [WIPER_W-1:0] wiper
);
  strobe_t    strb;
  logic [1:0] rdAddr;
  logic [7:0] rdData;
  logic       csAct;
  logic       sckFall;

  wiper_spi_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ID     (DEV_ID)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sck    (sck),
    .sdi    (sdi),
    .rdData (rdData),
    .rdAddr (rdAddr),
    .strb   (strb),
    .sdo    (sdo),
    .sdoOe  (sdoOe),
    .csAct  (csAct),
    .sckFall(sckFall)
  );

  wiper_reg_file #(
    .WIPER_W (WIPER_W),
    .INIT_POS(INIT_POS)
  ) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdAddr(rdAddr),
    .rdData(rdData),
    .wiper (wiper)
  );
endmodule

// File: rtl/wiper_spi_chk.sv
module wiper_spi_chk
  import wiper_spi_pkg::*;
#(
  parameter int WIPER_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               csN,
  input logic               sdo,
  input logic               sdoOe,
  input logic [WIPER_W-1:0] wiper,
  input strobe_t            strb,
  input logic               csAct,
  input logic               sckFall
);
  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !sdoOe);

  // R7
  sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe) && !$past(sckFall)) |-> $stable(sdo));

  // R6
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sharedWr |=> $stable(wiper));

  // R10
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr || strb.sharedWr) |-> $past(csAct));

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctlWr, strb.sharedWr}));
endmodule

bind wiper_spi_target wiper_spi_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .sdo    (sdo),
  .sdoOe  (sdoOe),
  .wiper  (wiper),
  .strb   (strb),
  .csAct  (csAct),
  .sckFall(sckFall)
);

// File: tb/sim_wiper_spi_target.sv
`timescale 1ns/1ps
module sim_wiper_spi_target;
  localparam int HALF = 8;
  localparam logic [7:0] ID = 8'h50;
  localparam logic [3:0] OPW = 4'b1011;
  localparam logic [3:0] OPR = 4'b1001;
  localparam int NV = 17;
  // {isRead, op, addr, data, expRead, expWiper}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, OPR, 2'd3, 8'h00, 8'h00, 7'h40},
    {1'b1, OPR, 2'd0, 8'h00, 8'h40, 7'h40},
    {1'b0, OPW, 2'd0, 8'h15, 8'h00, 7'h15},
    {1'b1, OPR, 2'd0, 8'h00, 8'h15, 7'h15},
    {1'b0, OPW, 2'd3, 8'h80, 8'h00, 7'h15},
    {1'b1, OPR, 2'd3, 8'h00, 8'h80, 7'h15},
    {1'b0, OPW, 2'd0, 8'h7F, 8'h00, 7'h7F},
    {1'b1, OPR, 2'd0, 8'h00, 8'h7F, 7'h7F},
    {1'b0, OPW, 2'd3, 8'h00, 8'h00, 7'h7F},
    {1'b1, OPR, 2'd0, 8'h00, 8'h15, 7'h7F},
    {1'b0, OPW, 2'd0, 8'h00, 8'h00, 7'h00},
    {1'b0, OPW, 2'd3, 8'h80, 8'h00, 7'h00},
    {1'b0, OPW, 2'd0, 8'h2A, 8'h00, 7'h2A},
    {1'b0, OPW, 2'd3, 8'h00, 8'h00, 7'h2A},
    {1'b1, OPR, 2'd0, 8'h00, 8'h00, 7'h2A},
    {1'b0, OPW, 2'd0, 8'hD5, 8'h00, 7'h55},
    {1'b1, OPR, 2'd0, 8'h00, 8'h55, 7'h55}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdoOe;
  logic [6:0] wiper;
  int nTests = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  wiper_spi_target u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .wiper(wiper)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doFrame(input logic [7:0] id, input logic [3:0] op, input logic [1:0] adr,
                         input logic [7:0] dat, input int nBits,
                         output logic [7:0] rd, output logic hdrQuiet, output logic oeSeen);
    logic [23:0] word;
    word = {id, op, 2'b00, adr, dat};
    rd = 8'h00; hdrQuiet = 1'b1; oeSeen = 1'b1;
    @(negedge clk); csN = 1'b0; sck = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      sck = 1'b0; sdi = word[23-i];
      repeat (HALF) @(negedge clk);
      if (!sdoOe) oeSeen = 1'b0;
      if (i >= 16) rd = {rd[6:0], sdo};
      else if (sdo !== 1'b0) hdrQuiet = 1'b0;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic q, oe;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R8 idle enable
    chk("R1 reset wiper", {1'b0, wiper}, 8'h40);
    chk("R8 idle sdoOe", {7'd0, sdoOe}, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      doFrame(ID, VEC[v][28:25], VEC[v][24:23], VEC[v][22:15], 24, rd, q, oe);
      chk($sformatf("R4 R5 R6 step %0d wiper", v), {1'b0, wiper}, {1'b0, VEC[v][6:0]});
      chk($sformatf("R8 step %0d oe in frame", v), {7'd0, oe}, 8'h01);
      chk($sformatf("R8 step %0d oe after", v), {7'd0, sdoOe}, 8'h00);
      if (VEC[v][29]) begin
        chk($sformatf("R3 R6 R7 step %0d read", v), rd, VEC[v][14:7]);
        chk($sformatf("R7 step %0d header quiet", v), {7'd0, q}, 8'h01);
      end
    end

    // R9 wrong identifier
    doFrame(8'h51, OPW, 2'd0, 8'h11, 24, rd, q, oe);
    chk("R9 bad id wiper", {1'b0, wiper}, 8'h55);
    // R9 unknown op
    doFrame(ID, 4'b1111, 2'd0, 8'h11, 24, rd, q, oe);
    chk("R9 bad op wiper", {1'b0, wiper}, 8'h55);
    // R9 unmapped addresses
    doFrame(ID, OPW, 2'd1, 8'h80, 24, rd, q, oe);
    doFrame(ID, OPW, 2'd2, 8'h80, 24, rd, q, oe);
    chk("R9 unmapped wiper", {1'b0, wiper}, 8'h55);
    doFrame(ID, OPR, 2'd3, 8'h00, 24, rd, q, oe);
    chk("R9 control untouched", rd, 8'h00);
    doFrame(ID, OPR, 2'd1, 8'h00, 24, rd, q, oe);
    chk("R9 unmapped read", rd, 8'h00);
    doFrame(ID, OPR, 2'd0, 8'h00, 24, rd, q, oe);
    chk("R9 power-up untouched", rd, 8'h55);

    // R10 truncated writes
    doFrame(ID, OPW, 2'd0, 8'h22, 20, rd, q, oe);
    doFrame(ID, OPW, 2'd0, 8'h22, 23, rd, q, oe);
    chk("R10 truncated wiper", {1'b0, wiper}, 8'h55);
    doFrame(ID, OPR, 2'd0, 8'h00, 24, rd, q, oe);
    chk("R10 truncated power-up", rd, 8'h55);
    doFrame(ID, OPW, 2'd3, 8'h80, 20, rd, q, oe);
    doFrame(ID, OPR, 2'd3, 8'h00, 24, rd, q, oe);
    chk("R10 truncated control", rd, 8'h00);

    // R1 later reset restores defaults
    doFrame(ID, OPW, 2'd3, 8'h80, 24, rd, q, oe);
    doFrame(ID, OPW, 2'd0, 8'h2A, 24, rd, q, oe);
    chk("R4 pre-reset wiper", {1'b0, wiper}, 8'h2A);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 re-reset wiper", {1'b0, wiper}, 8'h40);
    doFrame(ID, OPR, 2'd3, 8'h00, 24, rd, q, oe);
    chk("R1 re-reset control", rd, 8'h00);
    doFrame(ID, OPR, 2'd0, 8'h00, 24, rd, q, oe);
    chk("R1 re-reset power-up", rd, 8'h40);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule